// File: doc/BRIEF.md
# Power-Save and Soft-Reset Mode Controller

This controller turns two power-down configuration bits into enables for a converter's oscillator, analog bias and digital filter. It has three operating states: normal, standby and sleep. Standby keeps the oscillator and bias running, so it can return to normal at once. Sleep stops the oscillator, so when the internal oscillator is in use, the way back to normal passes through a wake state. That state counts a parameterised number of slow timebase ticks before the ready flag rises. When an external clock source is flagged, sleep exits straight to normal.

The same block sequences a soft reset. A write strobe of the reset bit drives an internal reset pulse for a fixed number of cycles, and the bit then clears itself. When the pulse ends, a reset-valid flag is raised, and it stays up until software reads the configuration register. All pins are plain level or strobe control and status. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Out of reset the block is in normal mode (`pwr_mode` code 0), with `osc_en`, `bias_en`, `filt_en` and `ready` all at 1 and `soft_rst` and `rst_valid` at 0.
- R2: In normal mode with `cfg_pdw`=1 and `cfg_pss`=0, the block enters standby (code 1) one cycle later. In standby `osc_en`=1, `bias_en`=1, `filt_en`=0 and `ready`=0.
- R3: With `cfg_pdw`=1 and `cfg_pss`=1, the block enters sleep (code 2) one cycle later, from normal or from standby. In sleep `osc_en`, `bias_en`, `filt_en` and `ready` are all 0.
- R4: Clearing `cfg_pdw` while in standby returns the block to normal one cycle later, with `ready`=1 and no tick wait.
- R5: While in sleep with `cfg_pdw`=1, a change of `cfg_pss` has no effect, and the block stays in sleep.
- R6: Clearing `cfg_pdw` in sleep with `ext_clk_sel`=0 enters wake (code 3) one cycle later. In wake `osc_en`=1, `bias_en`=1, `filt_en`=0 and `ready`=0. The block moves to normal one cycle after the clock edge that samples the WAKE_TICKS-th `wake_tick` pulse. Cycles without a tick do not count.
- R7: Clearing `cfg_pdw` in sleep with `ext_clk_sel`=1 returns the block to normal one cycle later, with `ready`=1.
- R8: Setting `cfg_pdw` while in wake abandons the wait and enters sleep one cycle later. The next exit from sleep starts the tick count again from zero.
- R9: A one-cycle `cfg_rs_wr` strobe, in any mode, holds `soft_rst` at 1 for exactly RST_LEN cycles, starting one cycle later. During that time `filt_en` is 0, and the power mode does not change.
- R10: `rst_valid` rises in the same cycle that `soft_rst` falls. It then holds until a `cfg_rd` strobe clears it. A read that coincides with the completion of a reset leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pdw | input | 1 | Power-down request bit |
| cfg_pss | input | 1 | Power-save select: 0 standby, 1 sleep |
| cfg_rs_wr | input | 1 | Strobe: reset bit written as 1 |
| cfg_rd | input | 1 | Strobe: configuration register read |
| ext_clk_sel | input | 1 | 1 when an external clock replaces the oscillator |
| wake_tick | input | 1 | Slow timebase pulse that counts the start-up wait |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Analog bias enable |
| filt_en | output | 1 | Filter engine enable |
| ready | output | 1 | Normal operation available |
| soft_rst | output | 1 | Internal soft reset pulse (readable, self-clearing reset bit) |
| rst_valid | output | 1 | Reset-completed status flag |
| pwr_mode | output | 2 | 0 normal, 1 standby, 2 sleep, 3 wake |

## Verification
The hardest case to reach is a wake wait that was abandoned part way, because the tick count left behind is not visible at any port. The stimulus gives two ticks in wake, sets the power-down bit again, and then leaves sleep once more. It then supplies WAKE_TICKS-1 fresh ticks, which is more than the remainder of the first wait. The block must still be in wake at that point, and only the final tick may release `ready`. Ticks are spaced with idle cycles so that a counter that counts clock cycles would release early.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STBY  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic osc;
    logic bias;
    logic filt;
    logic rdy;
  } pwr_en_t;

  function automatic pwr_en_t state_enables(pwr_state_e st);
    pwr_en_t e;
    case (st)
      ST_RUN:   e = '{osc: 1'b1, bias: 1'b1, filt: 1'b1, rdy: 1'b1};
      ST_STBY:  e = '{osc: 1'b1, bias: 1'b1, filt: 1'b0, rdy: 1'b0};
      ST_WAKE:  e = '{osc: 1'b1, bias: 1'b1, filt: 1'b0, rdy: 1'b0};
      default:  e = '{osc: 1'b0, bias: 1'b0, filt: 1'b0, rdy: 1'b0};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int WAKE_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(WAKE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS);

  logic          running;
  logic [CW-1:0] cnt;

  assign done = running && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (abort || done) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (running && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdw,
  input  logic       pss,
  input  logic       ext_clk,
  input  logic       wake_done,
  output pwr_state_e state,
  output logic       wake_start,
  output logic       wake_abort
);
  pwr_state_e nxt;

  assign wake_start = (state == ST_SLEEP) && !pdw && !ext_clk;
  assign wake_abort = (state == ST_WAKE) && pdw;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:   if (pdw) nxt = pss ? ST_SLEEP : ST_STBY;
      ST_STBY:  if (!pdw) nxt = ST_RUN;
                else if (pss) nxt = ST_SLEEP;
      ST_SLEEP: if (!pdw) nxt = ext_clk ? ST_RUN : ST_WAKE;
      ST_WAKE:  if (pdw) nxt = ST_SLEEP;
                else if (wake_done) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_soft_reset.sv
module pwr_soft_reset #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rs_wr,
  input  logic cfg_rd,
  output logic active,
  output logic valid
);
  localparam int CW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_LEN - 1);

  logic [CW-1:0] cnt;
  logic          finish;

  assign finish = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (rs_wr) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (finish) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid <= 1'b0;
    else if (finish && !rs_wr) valid <= 1'b1;
    else if (cfg_rd) valid <= 1'b0;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int WAKE_TICKS = 20,
  parameter int RST_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pdw,
  input  logic       cfg_pss,
  input  logic       cfg_rs_wr,
  input  logic       cfg_rd,
  input  logic       ext_clk_sel,
  input  logic       wake_tick,
  output logic       osc_en,
  output logic       bias_en,
  output logic       filt_en,
  output logic       ready,
  output logic       soft_rst,
  output logic       rst_valid,
  output logic [1:0] pwr_mode
);
  pwr_state_e st;
  pwr_en_t    en;
  logic       wk_start, wk_abort, wk_done;

  pwr_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdw        (cfg_pdw),
    .pss        (cfg_pss),
    .ext_clk    (ext_clk_sel),
    .wake_done  (wk_done),
    .state      (st),
    .wake_start (wk_start),
    .wake_abort (wk_abort)
  );

  pwr_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wk_start),
    .abort (wk_abort),
    .tick  (wake_tick),
    .done  (wk_done)
  );

  pwr_soft_reset #(.RST_LEN(RST_LEN)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rs_wr  (cfg_rs_wr),
    .cfg_rd (cfg_rd),
    .active (soft_rst),
    .valid  (rst_valid)
  );

  assign en       = state_enables(st);
  assign osc_en   = en.osc;
  assign bias_en  = en.bias;
  assign filt_en  = en.filt && !soft_rst;
  assign ready    = en.rdy;
  assign pwr_mode = st;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pdw,
  input logic       cfg_pss,
  input logic       ext_clk_sel,
  input logic       osc_en,
  input logic       bias_en,
  input logic       filt_en,
  input logic       ready,
  input logic       soft_rst,
  input logic       rst_valid,
  input logic [1:0] pwr_mode
);
  a_r2_standby_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd1) |-> (osc_en && bias_en && !filt_en && !ready));

  a_r3_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2) |-> (!osc_en && !bias_en && !ready));

  a_r4_standby_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd1 && !cfg_pdw) |=> (pwr_mode == 2'd0 && ready));

  a_r5_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2 && cfg_pdw) |=> (pwr_mode == 2'd2));

  a_r7_ext_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2 && !cfg_pdw && ext_clk_sel) |=> (pwr_mode == 2'd0));

  a_r6_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2 && !cfg_pdw && !ext_clk_sel) |=> (pwr_mode == 2'd3 && !ready));

  a_r9_filter_gated: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !filt_en);

  a_r10_valid_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_valid) |-> $fell(soft_rst));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int WT = 6;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pdw = 1'b0, cfg_pss = 1'b0, cfg_rs_wr = 1'b0, cfg_rd = 1'b0;
  logic ext_clk_sel = 1'b0, wake_tick = 1'b0;
  logic osc_en, bias_en, filt_en, ready, soft_rst, rst_valid;
  logic [1:0] pwr_mode;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.WAKE_TICKS(WT), .RST_LEN(RL)) u_dut (.*);

  typedef struct {
    string      req;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // vector: {osc, bias, filt, ready, soft_rst, rst_valid, mode[1:0]}
  function automatic logic [7:0] v(bit o, bit b, bit f, bit r, bit s, bit rv, logic [1:0] m);
    return {o, b, f, r, s, rv, m};
  endfunction

  localparam logic [1:0] M_RUN = 2'd0, M_STBY = 2'd1, M_SLP = 2'd2, M_WAKE = 2'd3;

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_v(string req, logic [7:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    q.push_back(it);
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      wake_tick = 1'b1;
      step(1);
      wake_tick = 1'b0;
      step(3);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = {osc_en, bias_en, filt_en, ready, soft_rst, rst_valid, pwr_mode};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %b expected %b", it.req, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    expect_v("R1 reset", v(1,1,1,1,0,0,M_RUN));
    rst_n = 1'b1;
    step(2);
    expect_v("R1 after release", v(1,1,1,1,0,0,M_RUN));

    // R2 standby entry
    cfg_pdw = 1'b1; cfg_pss = 1'b0;
    step(1);
    expect_v("R2 standby", v(1,1,0,0,0,0,M_STBY));
    // R4 quick exit
    cfg_pdw = 1'b0;
    step(1);
    expect_v("R4 standby exit", v(1,1,1,1,0,0,M_RUN));

    // R3 standby to sleep
    cfg_pdw = 1'b1; cfg_pss = 1'b0;
    step(1);
    cfg_pss = 1'b1;
    step(1);
    expect_v("R3 standby to sleep", v(0,0,0,0,0,0,M_SLP));

    // R5 PSS ignored in sleep
    cfg_pss = 1'b0;
    step(3);
    expect_v("R5 pss ignored", v(0,0,0,0,0,0,M_SLP));

    // R6 wake wait with internal oscillator
    cfg_pdw = 1'b0; ext_clk_sel = 1'b0;
    step(1);
    expect_v("R6 wake entry", v(1,1,0,0,0,0,M_WAKE));
    step(10);
    expect_v("R6 idle cycles not counted", v(1,1,0,0,0,0,M_WAKE));
    pulse_ticks(WT - 1);
    expect_v("R6 one tick short", v(1,1,0,0,0,0,M_WAKE));
    wake_tick = 1'b1;
    step(1);
    wake_tick = 1'b0;
    expect_v("R6 last tick sampled", v(1,1,0,0,0,0,M_WAKE));
    step(1);
    expect_v("R6 normal after wait", v(1,1,1,1,0,0,M_RUN));

    // R3 direct sleep from normal, R7 external clock exit
    cfg_pdw = 1'b1; cfg_pss = 1'b1;
    step(1);
    expect_v("R3 normal to sleep", v(0,0,0,0,0,0,M_SLP));
    ext_clk_sel = 1'b1; cfg_pdw = 1'b0;
    step(1);
    expect_v("R7 external clock exit", v(1,1,1,1,0,0,M_RUN));
    ext_clk_sel = 1'b0;

    // R8 abort wake and restart count
    cfg_pdw = 1'b1;
    step(1);
    cfg_pdw = 1'b0;
    step(1);
    expect_v("R8 wake entry", v(1,1,0,0,0,0,M_WAKE));
    pulse_ticks(2);
    cfg_pdw = 1'b1;
    step(1);
    expect_v("R8 abort to sleep", v(0,0,0,0,0,0,M_SLP));
    cfg_pdw = 1'b0;
    step(1);
    pulse_ticks(WT - 1);
    expect_v("R8 count restarted", v(1,1,0,0,0,0,M_WAKE));
    pulse_ticks(1);
    expect_v("R8 normal after full wait", v(1,1,1,1,0,0,M_RUN));

    // R9 soft reset in normal
    cfg_rs_wr = 1'b1;
    step(1);
    cfg_rs_wr = 1'b0;
    expect_v("R9 reset pulse start", v(1,1,0,1,1,0,M_RUN));
    step(RL - 1);
    expect_v("R9 reset pulse last cycle", v(1,1,0,1,1,0,M_RUN));
    step(1);
    expect_v("R10 valid set at end", v(1,1,1,1,0,1,M_RUN));
    step(3);
    expect_v("R10 valid holds", v(1,1,1,1,0,1,M_RUN));
    cfg_rd = 1'b1;
    step(1);
    cfg_rd = 1'b0;
    expect_v("R10 read clears", v(1,1,1,1,0,0,M_RUN));

    // R9 soft reset during standby keeps mode
    cfg_pdw = 1'b1; cfg_pss = 1'b0;
    step(1);
    cfg_rs_wr = 1'b1;
    step(1);
    cfg_rs_wr = 1'b0;
    expect_v("R9 reset in standby", v(1,1,0,0,1,0,M_STBY));
    step(RL - 1);
    cfg_rd = 1'b1;
    step(1);
    cfg_rd = 1'b0;
    expect_v("R10 read at completion keeps valid", v(1,1,0,0,0,1,M_STBY));
    cfg_pdw = 1'b0;
    step(1);
    expect_v("R4 exit after reset", v(1,1,1,1,0,1,M_RUN));

    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule